// File: doc/BRIEF.md
# Edge and Gated-Time Pulse Accumulator

This block counts activity on a single input pin into a 16-bit accumulator. It has two modes. In event mode it counts one edge polarity of the pin. In gated mode it counts a tick from a free-running divide-by-64 prescaler for as long as the pin sits at a chosen level. The enable bit in the control register starts and stops counting on its own. No other timer logic is needed for the block to run.

Two sticky flags record what happened. The overflow flag is set when the accumulator wraps. The edge flag is set when the selected edge arrives; in gated mode this is the edge that closes the gate. Each flag has its own interrupt enable. Software uses a small word-wide register port and can read or write it at any time. Through this port it sets the control bits, clears flags by writing 1 to them, and reads or loads the counter. The port is single-cycle and takes no handshake: writes are accepted on every cycle that `reg_wr` is high, and reads are combinational.

The pin first passes through a two-flop synchronizer. After that the edge detector compares the current synchronized sample with the previous one. An edge on the pin therefore takes effect at the third rising clock edge after it is sampled.

Top module: `pulse_accum`

## Requirements
- R1: After reset the control register, both flags and the counter read 0, and both interrupt outputs are low.
- R2: Address 0 is the control register. It has enable at bit 6, mode at bit 5 (0 event, 1 gated), edge select at bit 4, a clock-select field at bits 3:2 that is stored and read back only, overflow interrupt enable at bit 1 and edge interrupt enable at bit 0. Bit 7 and above read 0. It can be written and read on any cycle.
- R3: While enable is 0, the counter does not change from pin activity, the flags are not set, and the mode and edge-select bits have no effect.
- R4: In event mode with enable set, each falling pin edge (edge select 0) or each rising pin edge (edge select 1) adds one to the counter and sets the edge flag.
- R5: In gated mode with enable set, the counter adds one on each prescaler tick while the synchronized pin is high (edge select 0) or low (edge select 1). The prescaler runs freely from reset and ticks once every 64 clocks, first on the 64th clock edge after reset.
- R6: In gated mode, the edge that closes the gate sets the edge flag. This is the falling edge for edge select 0 and the rising edge for edge select 1.
- R7: An increment from 0xFFFF yields 0x0000 and sets the overflow flag.
- R8: Address 1 holds the flags: overflow at bit 1 and edge at bit 0. Writing 1 to a bit clears it and writing 0 leaves it alone. A flag set in the same cycle wins over the clear.
- R9: Address 2 is the counter. A write loads it, and in the same cycle the write takes priority over an increment, which is then lost.
- R10: `irq_ovf` is high exactly when the overflow flag and its enable are both 1. `irq_edge` is high exactly when the edge flag and its enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous input pin being accumulated |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 flags, 2 counter) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_edge | output | 1 | Edge interrupt request |

## Verification
The hardest cases to reach from the ports are the ones that depend on the prescaler phase. Examples are a counter load that lands on the same cycle as a gated tick, and a gate that opens or closes close to a tick. The prescaler cannot be seen or reset except through the global reset. The stimulus therefore holds a gate open while it rewrites the counter on every cycle for longer than a full prescaler period, so that some write is sure to collide with a tick. A cycle-accurate model in the bench tracks the phase, and every interrupt output and every read is compared against that model. Overflow is reached quickly by loading 0xFFFE and then giving two counted edges.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam int CTRL_W = 7;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_FLAGS = 2'd1;
  localparam logic [1:0] ADDR_COUNT = 2'd2;

  localparam int FLAG_EDGE_BIT = 0;
  localparam int FLAG_OVF_BIT  = 1;

  // Packed so that enable lands on bit 6 and edge irq enable on bit 0.
  typedef struct packed {
    logic       en;
    logic       gated;
    logic       edge_sel;
    logic [1:0] clk_sel;
    logic       ovf_ie;
    logic       edge_ie;
  } ctrl_t;
endpackage

// File: rtl/pacc_sync_edge.sv
module pacc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

  // R4: a detected edge is never followed by the same edge on the next cycle
  a_r4_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [DIV_LOG2-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign tick = &cnt_q;

  // R5: the tick is a one-cycle pulse
  a_r5_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  assign wrap = inc & ~load & (&cnt);

  // R7: an increment from all ones yields zero
  a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && (&cnt)) |=> (cnt == '0));
  // R9: a load wins over an increment
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));
  // R3: without increment or load the counter holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(cnt));
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pacc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_LOG2    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq_ovf,
  output logic             irq_edge
);
  localparam int PAD_CTRL  = CNT_W - CTRL_W;
  localparam int PAD_FLAGS = CNT_W - 2;

  ctrl_t            ctrl_q;
  logic             ovf_flag, edge_flag;
  logic             lvl, rise, fall, tick;
  logic             edge_evt, gate_open, inc;
  logic             wr_ctrl, wr_flags, wr_cnt;
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_flags = reg_wr && (reg_addr == ADDR_FLAGS);
  assign wr_cnt   = reg_wr && (reg_addr == ADDR_COUNT);

  pacc_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .pin(pin_in),
    .level(lvl), .rise(rise), .fall(fall)
  );

  pacc_prescale #(.DIV_LOG2(DIV_LOG2)) i_presc (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  // The same edge counts in event mode and closes the gate in gated mode.
  assign edge_evt  = ctrl_q.edge_sel ? rise : fall;
  assign gate_open = (lvl != ctrl_q.edge_sel);
  assign inc       = ctrl_q.en && (ctrl_q.gated ? (tick && gate_open) : edge_evt);

  pacc_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .load(wr_cnt), .load_val(reg_wdata),
    .inc(inc), .cnt(cnt), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag  <= 1'b0;
      edge_flag <= 1'b0;
    end else begin
      ovf_flag  <= (ovf_flag  & ~(wr_flags & reg_wdata[FLAG_OVF_BIT]))  | wrap;
      edge_flag <= (edge_flag & ~(wr_flags & reg_wdata[FLAG_EDGE_BIT])) |
                   (ctrl_q.en & edge_evt);
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL:  reg_rdata = {{PAD_CTRL{1'b0}}, ctrl_q};
      ADDR_FLAGS: reg_rdata = {{PAD_FLAGS{1'b0}}, ovf_flag, edge_flag};
      ADDR_COUNT: reg_rdata = cnt;
      default:    reg_rdata = '0;
    endcase
  end

  assign irq_ovf  = ovf_flag  & ctrl_q.ovf_ie;
  assign irq_edge = edge_flag & ctrl_q.edge_ie;

  // R7: overflow flag only rises after a wrap
  a_r7_ovf_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(wrap));
  // R3: edge flag only rises while enabled
  a_r3_edge_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_flag) |-> $past(ctrl_q.en));
  // R8: a clear with no competing set empties the edge flag
  a_r8_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flags && reg_wdata[FLAG_EDGE_BIT] && !(ctrl_q.en && edge_evt)) |=> !edge_flag);
endmodule

// File: tb/test_pulse_accum.sv
module test_pulse_accum;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        irq_ovf, irq_edge;

  int checks = 0;
  int errors = 0;

  pulse_accum i_pulse_accum (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_ovf(irq_ovf), .irq_edge(irq_edge)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int     m_ctrl, m_cnt, m_phase;
  bit     m_ovf, m_edge;
  int     pin_hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_phase = 0; m_ovf = 0; m_edge = 0;
      pin_hist = '{0, 0, 0};
    end else begin
      bit seen, older, up, down, en, gmode, sel, tk, evt, inc, ld, s_ovf, s_edge, clr;
      seen  = pin_hist[1] != 0;
      older = pin_hist[2] != 0;
      up    = seen && !older;
      down  = !seen && older;
      en    = m_ctrl[6]; gmode = m_ctrl[5]; sel = m_ctrl[4];
      tk    = (m_phase % 64) == 63;
      m_phase++;
      evt   = sel ? up : down;
      inc   = en && (gmode ? (tk && (seen != sel)) : evt);
      ld    = reg_wr && reg_addr == 2;
      s_ovf = inc && !ld && m_cnt == 65535;
      s_edge = en && evt;
      if (ld) m_cnt = reg_wdata;
      else if (inc) m_cnt = (m_cnt + 1) % 65536;
      clr = reg_wr && reg_addr == 1;
      m_ovf  = (m_ovf  && !(clr && reg_wdata[1])) || s_ovf;
      m_edge = (m_edge && !(clr && reg_wdata[0])) || s_edge;
      if (reg_wr && reg_addr == 0) m_ctrl = reg_wdata[6:0];
      pin_hist.push_front(pin_in ? 1 : 0);
      void'(pin_hist.pop_back());
    end
  end

  function automatic int model_read(input int a);
    case (a)
      0: return m_ctrl;
      1: return (m_ovf ? 2 : 0) + (m_edge ? 1 : 0);
      2: return m_cnt;
      default: return 0;
    endcase
  endfunction

  // R10: interrupt outputs compared every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_o, e_e;
      e_o = m_ovf && m_ctrl[1];
      e_e = m_edge && m_ctrl[0];
      checks++;
      if (irq_ovf !== e_o || irq_edge !== e_e) begin
        errors++;
        $display("FAIL R10 irq ovf/edge actual %b%b expected %b%b", irq_ovf, irq_edge, e_o, e_e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    int exp;
    @(negedge clk); reg_addr = a; #1;
    exp = model_read(a);
    checks++;
    if (reg_rdata !== 16'(exp)) begin
      errors++;
      $display("FAIL %s addr %0d actual %h expected %h", tag, a, reg_rdata, 16'(exp));
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pin_in = ~pin_in;
      repeat (3) @(negedge clk);
      pin_in = ~pin_in;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1");
    if (reg_rdata !== 16'd0) $display("FAIL R1 counter actual %h expected 0000", reg_rdata);
    // R2 reserved bit 7 reads zero, all control bits writable
    wr(2'd0, 16'h00FF); rd(2'd0, "R2");
    wr(2'd0, 16'h000C); rd(2'd0, "R2");
    // R3 disabled: pin activity ignored in any mode setting
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0033);
    pin_in = 1'b0; pulses(6); idle(140);
    rd(2'd2, "R3"); rd(2'd1, "R3");
    // R4 event mode falling edges
    wr(2'd0, 16'h0043);
    pulses(5); idle(4);
    rd(2'd2, "R4"); rd(2'd1, "R4");
    wr(2'd1, 16'h0003); rd(2'd1, "R8");
    // R4 event mode rising edges
    wr(2'd0, 16'h0053);
    pulses(3); idle(4);
    rd(2'd2, "R4");
    // R9 load, R7 wrap
    wr(2'd2, 16'hFFFE); rd(2'd2, "R9");
    pulses(2); idle(4);
    rd(2'd2, "R7"); rd(2'd1, "R7");
    wr(2'd1, 16'h0002); rd(2'd1, "R8");
    // R5/R6 gated, high level
    wr(2'd1, 16'h0003); wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0063);
    @(negedge clk); pin_in = 1'b1; idle(200);
    rd(2'd2, "R5");
    @(negedge clk); pin_in = 1'b0; idle(5);
    rd(2'd2, "R5"); rd(2'd1, "R6");
    // R5/R6 gated, low level
    wr(2'd0, 16'h0073); wr(2'd1, 16'h0003);
    idle(130);
    @(negedge clk); pin_in = 1'b1; idle(5);
    rd(2'd2, "R5"); rd(2'd1, "R6");
    // R9 repeated loads while the gate is open span a tick
    wr(2'd0, 16'h0061);
    @(negedge clk); pin_in = 1'b1;
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h1234;
    idle(70);
    reg_wr = 1'b0;
    rd(2'd2, "R9");
    // R10 interrupt enables off hide flags
    wr(2'd0, 16'h0040); idle(80); rd(2'd1, "R10");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule